// File: doc/BRIEF.md
# Flash Status Word Generator

This block forms the word a flash device returns on a bus read while its embedded program or erase sequencer is busy, or while an erase is on hold. The sequencer supplies its current phase, a pulse when an operation fails, and a pulse when a reset command clears the failure. The read path supplies a read strobe, the block index of the read address, the bit 7 value being programmed, a mask of blocks chosen for erase and a mask of blocks whose erase failed.

Each cycle the block drives a 16-bit status word and a pass-through flag. When the flag is high, the read path returns array data instead of the status word. Two toggle bits are kept apart. Bit 6 flips on every status read. Bit 2 flips only when the read address falls in a block of interest: a block chosen for erase, or, after an erase failure, a block that failed. Software can therefore poll bit 2 across the array to find the block at fault.

Top module: `fsr_status_gen`

## Requirements
- R1: After synchronous reset, with the phase input idle, pass_thru is 1, stat_word is 0 and both toggle bits start at 0.
- R2: In phase code 1 (program) with no failure latched, bit 7 is the inverse of prog_d7, bits 5 and 3 are 0, bit 2 holds, and pass_thru is 0.
- R3: In phase code 2 (erase, selection window open) bit 7 is 0 and bit 3 is 0. In phase code 3 (erase running) bit 7 is 0 and bit 3 is 1. pass_thru is 0 in both.
- R4: Bit 6 inverts after every cycle with rd_stb high in phase codes 1, 2 and 3 or while a failure is latched, whatever the block index. In every other situation it holds.
- R5: In phase codes 2, 3 and 4, bit 2 inverts after a strobed read whose block index selects a block in ers_sel (bit i of the mask for index i). Reads of other blocks leave it unchanged.
- R6: In phase code 4 (erase suspended), a read of a selected block gives bit 7 = 1 and bit 3 = 1, and bit 6 holds. A read of an unselected block gives pass_thru = 1.
- R7: fail_set in phase code 1 or 3 latches a failure that shows as bit 5 = 1 from the next cycle. The failure stays latched, with status output, whatever the phase, until fail_clr, which wins over fail_set and clears it the next cycle.
- R8: With an erase failure latched, bit 7 is 0, bit 3 is 1, and bit 2 inverts only on strobed reads of blocks set in ers_bad. With a program failure latched, bit 7 is the inverse of prog_d7, bit 3 is 0 and bit 2 holds.
- R9: Entering phase code 1 or 2 directly from idle clears both toggle bits, so the first read in the new operation sees 0 in bits 6 and 2.
- R10: Bits 15 to 8, 4, 1 and 0 are always 0. stat_word is all zero whenever pass_thru is 1. Phase codes 0 and 5 to 7 are idle, and with no failure latched idle gives pass_thru = 1.
- R11: A cycle without rd_stb changes neither toggle bit, apart from the clear on operation start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 3 | Sequencer phase: 0 idle, 1 program, 2 erase window, 3 erase running, 4 erase suspended |
| rd_stb | input | 1 | One bus read this cycle |
| rd_blk | input | BLK_W (3) | Block index of the read address; values at or above NBLK select no block |
| ers_sel | input | NBLK (7) | Blocks chosen for erase |
| ers_bad | input | NBLK (7) | Blocks whose erase failed |
| prog_d7 | input | 1 | Bit 7 of the data being programmed |
| fail_set | input | 1 | Operation failure pulse |
| fail_clr | input | 1 | Reset command clears a latched failure |
| stat_word | output | DW (16) | Status word |
| pass_thru | output | 1 | Return array data instead of stat_word |

## Verification
The bench targets the two toggle bits. A design that shared one flip-flop between them would move bit 2 on reads of unselected blocks. A design that missed the clear on operation start would show a stale 1 on the first poll. During suspend the bench reads both selected and unselected blocks, and out-of-range indexes as well. A design that forgot the pass-through would return status for live data, and one that kept toggling bit 6 would tell software the erase was still running. Failure injection covers program and erase faults with fail_set and fail_clr in the same cycle. A latch that dropped on the next phase change, or an erase failure that toggled bit 2 on good blocks, would each show a mismatch.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_PROG  = 3'd1,
        PH_EWIN  = 3'd2,
        PH_ERUN  = 3'd3,
        PH_ESUSP = 3'd4
    } fsr_phase_e;

    // Control decided for the current read
    typedef struct packed {
        logic status_on;  // drive status instead of array data
        logic poll;       // bit 7 value
        logic timer;      // bit 3 value
        logic adv_any;    // bit 6 may advance on this read
        logic adv_blk;    // bit 2 may advance on this read
    } fsr_ctl_t;

    localparam int POS_POLL  = 7;
    localparam int POS_TOG   = 6;
    localparam int POS_FAIL  = 5;
    localparam int POS_TIMER = 3;
    localparam int POS_ALT   = 2;
    localparam int NUM_TOG   = 2;

    function automatic fsr_phase_e fsr_norm(input logic [2:0] raw);
        case (raw)
            3'd1:    return PH_PROG;
            3'd2:    return PH_EWIN;
            3'd3:    return PH_ERUN;
            3'd4:    return PH_ESUSP;
            default: return PH_IDLE;
        endcase
    endfunction

    function automatic logic fsr_starts(input fsr_phase_e prev, input fsr_phase_e cur);
        return (prev == PH_IDLE) && ((cur == PH_PROG) || (cur == PH_EWIN));
    endfunction

endpackage

// File: rtl/fsr_toggle.sv
module fsr_toggle (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic adv,
    output logic q_eff,
    output logic q_reg
);
    always_comb q_eff = clr ? 1'b0 : q_reg;

    always_ff @(posedge clk) begin
        if (rst) q_reg <= 1'b0;
        else     q_reg <= q_eff ^ adv;
    end
endmodule

// File: rtl/fsr_fail_latch.sv
module fsr_fail_latch import fsr_pkg::*; (
    input  logic       clk,
    input  logic       rst,
    input  fsr_phase_e phase,
    input  logic       fail_set,
    input  logic       fail_clr,
    output logic       err_q,
    output logic       err_ers_q
);
    logic can_fail;
    always_comb can_fail = (phase == PH_PROG) || (phase == PH_ERUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q     <= 1'b0;
            err_ers_q <= 1'b0;
        end else if (fail_clr) begin
            err_q     <= 1'b0;
            err_ers_q <= 1'b0;
        end else if (fail_set && can_fail && !err_q) begin
            err_q     <= 1'b1;
            err_ers_q <= (phase == PH_ERUN);
        end
    end
endmodule

// File: rtl/fsr_classify.sv
module fsr_classify import fsr_pkg::*; (
    input  fsr_phase_e phase,
    input  logic       err_q,
    input  logic       err_ers_q,
    input  logic       sel_hit,
    input  logic       bad_hit,
    input  logic       prog_d7,
    output fsr_ctl_t   ctl
);
    always_comb begin
        ctl = '0;
        if (err_q) begin
            ctl.status_on = 1'b1;
            ctl.poll      = err_ers_q ? 1'b0 : ~prog_d7;
            ctl.timer     = err_ers_q;
            ctl.adv_any   = 1'b1;
            ctl.adv_blk   = err_ers_q & bad_hit;
        end else begin
            unique case (phase)
                PH_PROG: begin
                    ctl.status_on = 1'b1;
                    ctl.poll      = ~prog_d7;
                    ctl.adv_any   = 1'b1;
                end
                PH_EWIN: begin
                    ctl.status_on = 1'b1;
                    ctl.adv_any   = 1'b1;
                    ctl.adv_blk   = sel_hit;
                end
                PH_ERUN: begin
                    ctl.status_on = 1'b1;
                    ctl.timer     = 1'b1;
                    ctl.adv_any   = 1'b1;
                    ctl.adv_blk   = sel_hit;
                end
                PH_ESUSP: begin
                    if (sel_hit) begin
                        ctl.status_on = 1'b1;
                        ctl.poll      = 1'b1;
                        ctl.timer     = 1'b1;
                        ctl.adv_blk   = 1'b1;
                    end
                end
                default: ctl = '0;
            endcase
        end
    end
endmodule

// File: rtl/fsr_status_gen.sv
module fsr_status_gen import fsr_pkg::*; #(
    parameter int NBLK = 7,
    parameter int DW   = 16,
    localparam int BLK_W = $clog2(NBLK + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       mode_i,
    input  logic             rd_stb,
    input  logic [BLK_W-1:0] rd_blk,
    input  logic [NBLK-1:0]  ers_sel,
    input  logic [NBLK-1:0]  ers_bad,
    input  logic             prog_d7,
    input  logic             fail_set,
    input  logic             fail_clr,
    output logic [DW-1:0]    stat_word,
    output logic             pass_thru
);
    fsr_phase_e phase, prev_mode_q;
    logic       op_start;
    logic       sel_hit, bad_hit;
    logic       err_q, err_ers_q;
    fsr_ctl_t   ctl;
    logic [NUM_TOG-1:0] t_adv, t_eff, t_reg;
    logic       t6_q, t2_q;

    always_comb phase    = fsr_norm(mode_i);
    always_comb op_start = fsr_starts(prev_mode_q, phase);

    always_ff @(posedge clk) begin
        if (rst) prev_mode_q <= PH_IDLE;
        else     prev_mode_q <= phase;
    end

    // Block lookup; indexes at or above NBLK hit nothing
    always_comb begin
        sel_hit = 1'b0;
        bad_hit = 1'b0;
        for (int i = 0; i < NBLK; i++) begin
            if (rd_blk == BLK_W'(i)) begin
                sel_hit = ers_sel[i];
                bad_hit = ers_bad[i];
            end
        end
    end

    fsr_fail_latch u_fail (
        .clk       (clk),
        .rst       (rst),
        .phase     (phase),
        .fail_set  (fail_set),
        .fail_clr  (fail_clr),
        .err_q     (err_q),
        .err_ers_q (err_ers_q)
    );

    fsr_classify u_cls (
        .phase     (phase),
        .err_q     (err_q),
        .err_ers_q (err_ers_q),
        .sel_hit   (sel_hit),
        .bad_hit   (bad_hit),
        .prog_d7   (prog_d7),
        .ctl       (ctl)
    );

    always_comb begin
        t_adv[0] = rd_stb & ctl.adv_any;
        t_adv[1] = rd_stb & ctl.adv_blk;
    end

    for (genvar g = 0; g < NUM_TOG; g++) begin : g_tog
        fsr_toggle u_tog (
            .clk   (clk),
            .rst   (rst),
            .clr   (op_start),
            .adv   (t_adv[g]),
            .q_eff (t_eff[g]),
            .q_reg (t_reg[g])
        );
    end

    always_comb t6_q = t_reg[0];
    always_comb t2_q = t_reg[1];

    always_comb begin
        stat_word = '0;
        if (ctl.status_on) begin
            stat_word[POS_POLL]  = ctl.poll;
            stat_word[POS_TOG]   = t_eff[0];
            stat_word[POS_FAIL]  = err_q;
            stat_word[POS_TIMER] = ctl.timer;
            stat_word[POS_ALT]   = t_eff[1];
        end
        pass_thru = ~ctl.status_on;
    end
endmodule

// File: rtl/fsr_status_gen_chk.sv
module fsr_status_gen_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic [2:0]    mode_i,
    input logic          rd_stb,
    input logic          prog_d7,
    input logic          fail_clr,
    input logic [DW-1:0] stat_word,
    input logic          pass_thru,
    input logic          err_q,
    input logic          sus_sel,
    input logic [2:0]    prev_mode_q,
    input logic          t6_q,
    input logic          t2_q
);
    logic starting;
    always_comb starting = (prev_mode_q == 3'd0) && ((mode_i == 3'd1) || (mode_i == 3'd2));

    assert_pass_zero_R10: assert property (@(posedge clk) disable iff (rst)
        pass_thru |-> (stat_word == '0));

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (!err_q && !t6_q && !t2_q));

    assert_prog_poll_R2: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 3'd1 && !err_q) |-> (!pass_thru && stat_word[7] == ~prog_d7));

    assert_susp_sel_R6: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 3'd4 && !err_q && sus_sel) |-> (!pass_thru && stat_word[7]));

    assert_any_toggle_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && mode_i == 3'd1 && prev_mode_q == 3'd1 && !err_q) |=> (t6_q != $past(t6_q)));

    assert_fail_clear_R7: assert property (@(posedge clk) disable iff (rst)
        fail_clr |=> !err_q);

    assert_fail_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (err_q && !fail_clr) |=> err_q);

    assert_no_read_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (!rd_stb && !starting) |=> ($stable(t6_q) && $stable(t2_q)));
endmodule

bind fsr_status_gen fsr_status_gen_chk #(.DW(DW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .mode_i      (mode_i),
    .rd_stb      (rd_stb),
    .prog_d7     (prog_d7),
    .fail_clr    (fail_clr),
    .stat_word   (stat_word),
    .pass_thru   (pass_thru),
    .err_q       (err_q),
    .sus_sel     (sel_hit),
    .prev_mode_q (prev_mode_q),
    .t6_q        (t6_q),
    .t2_q        (t2_q)
);

// File: tb/test_fsr_status_gen.sv
`timescale 1ns/1ps
module test_fsr_status_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  mode_i = 3'd0;
    logic        rd_stb = 1'b0;
    logic [2:0]  rd_blk = 3'd0;
    logic [6:0]  ers_sel = 7'd0;
    logic [6:0]  ers_bad = 7'd0;
    logic        prog_d7 = 1'b0;
    logic        fail_set = 1'b0;
    logic        fail_clr = 1'b0;
    logic [15:0] stat_word;
    logic        pass_thru;

    int n_chk = 0;
    int n_err = 0;

    // reference state
    bit         mt6 = 0, mt2 = 0, merr = 0, merre = 0;
    logic [2:0] mprev = 3'd0;

    always #2.5 clk = ~clk;

    fsr_status_gen i_fsr_status_gen (
        .clk (clk), .rst (rst), .mode_i (mode_i), .rd_stb (rd_stb),
        .rd_blk (rd_blk), .ers_sel (ers_sel), .ers_bad (ers_bad),
        .prog_d7 (prog_d7), .fail_set (fail_set), .fail_clr (fail_clr),
        .stat_word (stat_word), .pass_thru (pass_thru)
    );

    function automatic logic [2:0] nm(input logic [2:0] m);
        return (m > 3'd4) ? 3'd0 : m;
    endfunction

    task automatic chk(input string tag, input string what, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
        end
    endtask

    // expected outputs and toggle enables from the requirements
    function automatic void expect_now(output bit ps, output logic [15:0] w,
                                       output bit a6, output bit a2, output bit e6, output bit e2);
        logic [2:0] m;
        bit st, hs, hb, on, poll, tim;
        m  = nm(mode_i);
        st = (mprev == 3'd0) && (m == 3'd1 || m == 3'd2);
        e6 = st ? 1'b0 : mt6;
        e2 = st ? 1'b0 : mt2;
        hs = (rd_blk < 3'd7) ? ers_sel[rd_blk] : 1'b0;
        hb = (rd_blk < 3'd7) ? ers_bad[rd_blk] : 1'b0;
        on = 0; poll = 0; tim = 0; a6 = 0; a2 = 0;
        if (merr) begin
            on = 1; poll = merre ? 1'b0 : ~prog_d7; tim = merre; a6 = 1; a2 = merre & hb;
        end else begin
            case (m)
                3'd1: begin on = 1; poll = ~prog_d7; a6 = 1; end
                3'd2: begin on = 1; a6 = 1; a2 = hs; end
                3'd3: begin on = 1; tim = 1; a6 = 1; a2 = hs; end
                3'd4: if (hs) begin on = 1; poll = 1; tim = 1; a2 = 1; end
                default: on = 0;
            endcase
        end
        ps = !on;
        w  = on ? {8'h00, poll, e6, merr, 1'b0, tim, e2, 2'b00} : 16'h0000;
    endfunction

    task automatic step(input logic [2:0] m, input logic r, input logic [2:0] b,
                        input logic s, input logic c);
        bit ps, a6, a2, e6, e2, n6, n2, nerr, nerre;
        logic [15:0] w;
        logic [2:0] mn;
        string t7, t2;
        mode_i = m; rd_stb = r; rd_blk = b; fail_set = s; fail_clr = c;
        #1;
        expect_now(ps, w, a6, a2, e6, e2);
        mn = nm(m);
        t7 = merr ? "R8" : (mn == 3'd1) ? "R2" : (mn == 3'd4) ? "R6" : "R3";
        t2 = merr ? "R8" : "R5";
        chk((mn == 3'd4) ? "R6" : "R10", "pass_thru", {15'd0, pass_thru}, {15'd0, ps});
        chk(t7, "bit7", {15'd0, stat_word[7]}, {15'd0, w[7]});
        chk(t7, "bit3", {15'd0, stat_word[3]}, {15'd0, w[3]});
        chk("R4", "bit6", {15'd0, stat_word[6]}, {15'd0, w[6]});
        chk(t2, "bit2", {15'd0, stat_word[2]}, {15'd0, w[2]});
        chk("R7", "bit5", {15'd0, stat_word[5]}, {15'd0, w[5]});
        chk("R10", "unused bits", stat_word & 16'hFF13, 16'h0000);
        n6 = e6 ^ (r & a6);
        n2 = e2 ^ (r & a2);
        nerr = merr; nerre = merre;
        if (c) begin nerr = 0; nerre = 0; end
        else if (s && !merr && (mn == 3'd1 || mn == 3'd3)) begin nerr = 1; nerre = (mn == 3'd3); end
        @(posedge clk);
        mt6 = n6; mt2 = n2; merr = nerr; merre = nerre; mprev = mn;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic keep6;
        logic [2:0] cur;
        void'($urandom(32'd20240607));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        chk("R1", "pass_thru after reset", {15'd0, pass_thru}, 16'd1);
        chk("R1", "word after reset", stat_word, 16'h0000);
        @(negedge clk);

        // R4: three program polls toggle bit 6
        prog_d7 = 1'b1;
        step(3'd1, 1, 3'd0, 0, 0);
        step(3'd1, 1, 3'd5, 0, 0);
        step(3'd1, 1, 3'd7, 0, 0);
        // R11: no read, bit 6 holds
        keep6 = stat_word[6];
        step(3'd1, 0, 3'd0, 0, 0);
        step(3'd1, 0, 3'd0, 0, 0);
        #1;
        chk("R11", "bit6 with no reads", {15'd0, stat_word[6]}, {15'd0, keep6});
        @(negedge clk);
        step(3'd0, 0, 3'd0, 0, 0);
        // R9: new operation clears toggles on its first cycle
        mode_i = 3'd2; #1;
        chk("R9", "bit6 at op start", {15'd0, stat_word[6]}, 16'd0);
        chk("R9", "bit2 at op start", {15'd0, stat_word[2]}, 16'd0);
        @(negedge clk);
        step(3'd0, 0, 3'd0, 0, 0);

        // erase with a failing block
        ers_sel = 7'b0000110; ers_bad = 7'b0000100;
        step(3'd2, 1, 3'd1, 0, 0);
        step(3'd2, 1, 3'd3, 0, 0);
        step(3'd3, 1, 3'd2, 0, 0);
        step(3'd3, 0, 3'd0, 1, 0);
        step(3'd0, 1, 3'd2, 0, 0);
        step(3'd0, 1, 3'd1, 0, 0);
        step(3'd0, 1, 3'd2, 0, 0);
        step(3'd0, 1, 3'd2, 1, 1);
        #1;
        chk("R7", "pass_thru after clear", {15'd0, pass_thru}, 16'd1);
        @(negedge clk);

        // suspend: selected and unselected blocks
        step(3'd0, 0, 3'd0, 0, 0);
        step(3'd2, 0, 3'd0, 0, 0);
        step(3'd3, 1, 3'd1, 0, 0);
        step(3'd4, 1, 3'd1, 0, 0);
        step(3'd4, 1, 3'd0, 0, 0);
        step(3'd4, 1, 3'd2, 0, 0);
        step(3'd4, 1, 3'd7, 0, 0);
        step(3'd1, 1, 3'd0, 1, 0);
        step(3'd0, 1, 3'd0, 0, 1);

        // constrained random
        cur = 3'd0;
        for (int k = 0; k < 3000; k++) begin
            if ($urandom % 8 == 0) cur = 3'($urandom % 6);
            if ($urandom % 64 == 0) begin
                ers_sel = 7'($urandom);
                ers_bad = 7'($urandom) & ers_sel;
            end
            prog_d7 = 1'($urandom);
            step(cur, 1'($urandom % 2), 3'($urandom % 8),
                 ($urandom % 40 == 0), ($urandom % 50 == 0));
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule